// File: doc/BRIEF.md
# Data Access Address Translator with Fault Syndrome

This block sits between a load/store pipeline and a translation buffer. For each request it takes a virtual address, an access size and a set of request qualifiers. It checks alignment and the canonical form of the address. It recognises the kernel direct-mapped window, looks the page up through an external combinational lookup port, and applies the read or write permission of the effective privilege mode. One cycle later it returns a physical address and a fault code.

When a request faults in a way that software must see, the block records the faulting address, a packed status syndrome and a formatted page-table address in three output registers. It also keeps separate hit, miss and violation counters for loads and for stores. Page-table-entry fetches and requests marked no-fault translate normally but leave the three fault registers untouched. The lookup port gets the virtual page number and the address space number in the same cycle, and returns hit, page frame, per-mode read and write enables, and the two fault-on-access bits.

Top module: `dacc_xlate`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high on the next cycle, with that request's `rsp_pa` and `rsp_fault`; without a request `rsp_valid` is low on the next cycle. Fault codes: 0 none, 1 misaligned, 2 access violation, 3 fault-on-read/write, 4 miss, 5 page-table-fetch miss, 6 machine check.
- R2: An address whose low bits are not a multiple of the size (`req_size` 0/1/2/3 = 1/2/4/8 bytes) gives code 1. It changes neither the fault registers nor any counter. This check comes before every other check.
- R3: The mode used for permission checks (0 kernel, 1 executive, 2 supervisor, 3 user) is `cur_mode`. When `pc_priv` is high it is instead kernel, or `alt_mode` if `req_alt` is also high. Enable bit N of the lookup port grants mode N.
- R4: With `req_phys` low, an address whose bits 63:42 are not all equal gives code 2, with syndrome flags bad-VA and violation, plus write for stores.
- R5: An address with bits 47:41 equal to 0x7E bypasses the lookup port. It is legal only when `cur_mode` is kernel, and then the PA is bits 40:0 of the address, with bit 40 copied into bits 43:41. Otherwise it gives code 2 with the violation flag, plus write for stores.
- R6: A lookup miss gives code 5 for a page-table fetch and code 4 otherwise, with the miss flag plus write for stores.
- R7: A store whose write enable lacks the mode bit gives code 2 with flags write, violation, and fault-on-write if the entry has it. A store that passes the enable but has fault-on-write set gives code 3 with flags write and fault-on-write.
- R8: A load does the same with the read enable and fault-on-read: code 2 with violation (plus fault-on-read if set), else code 3 with fault-on-read alone.
- R9: The syndrome is {opcode[5:0], register[4:0], flags[5:0]}, with flags bit 0 write, 1 violation, 2 fault-on-read, 3 fault-on-write, 4 miss, 5 bad-VA. On codes 2 to 5, when neither `req_ptefetch` nor `req_nofault` is set, `fault_va` takes the address, `mm_stat` takes the syndrome, and `va_form` takes `ptbr` OR (VA bits 42:13 shifted left by 3).
- R10: On a lookup hit the PA is (PFN << 13) | VA bits 12:0. Any PA bit at or above bit 44 gives code 6. The lookup port carries VA bits 42:13 and `asn`.
- R11: The counters advance by one per request. The read or write counter is chosen by `req_wr`. Misses count as miss. Codes 2 and 3 count as violation. A completed mapped or direct-window translation counts as hit, including one that then takes code 6.
- R12: With `req_phys` high the PA equals the VA. The canonical, window and lookup checks are skipped, no counter moves, and only the machine check applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | Access size code |
| req_wr | input | 1 | Store when high |
| req_phys | input | 1 | Address is already physical |
| req_alt | input | 1 | Use alternate mode in privileged code |
| req_ptefetch | input | 1 | Request is a page-table-entry fetch |
| req_nofault | input | 1 | Do not record fault state |
| pc_priv | input | 1 | Program counter bit 0 (privileged code) |
| cur_mode | input | 2 | Current mode register |
| alt_mode | input | 2 | Alternate mode register |
| asn | input | 8 | Address space number |
| ptbr | input | 64 | Page table base for formatted VA |
| inst_op | input | 6 | Opcode of the faulting instruction |
| inst_ra | input | 5 | Register field of the faulting instruction |
| lk_vpn | output | 30 | Lookup virtual page number |
| lk_asn | output | 8 | Lookup address space number |
| lk_hit | input | 1 | Lookup hit |
| lk_pfn | input | 32 | Page frame number |
| lk_rd_en | input | 4 | Read enable per mode |
| lk_wr_en | input | 4 | Write enable per mode |
| lk_for | input | 1 | Fault on read |
| lk_fow | input | 1 | Fault on write |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 64 | Physical address |
| rsp_fault | output | 3 | Fault code |
| fault_va | output | 64 | Recorded faulting address |
| mm_stat | output | 17 | Recorded syndrome |
| va_form | output | 64 | Recorded formatted address |
| cnt_rd_hit | output | 16 | Load hits |
| cnt_rd_miss | output | 16 | Load misses |
| cnt_rd_acv | output | 16 | Load violations |
| cnt_wr_hit | output | 16 | Store hits |
| cnt_wr_miss | output | 16 | Store misses |
| cnt_wr_acv | output | 16 | Store violations |

## Verification
Some rules hold on every cycle, and the assertions check those: the one-cycle response pairing, the precedence of misalignment, the silence of the fault registers on page-table fetches, that a clean result never carries bits beyond the implemented width, and that the miss counters and the table-fetch miss code move only on a miss. The bench's directed scenarios are needed for the rest. These are the exact syndrome flag combinations in the two-step permission ordering, the mode chosen in privileged code, the sign copy in the direct window, the formatted address, and the choice of read or write counter.

// File: rtl/dacc_xlate.sv
module dacc_xlate #(
  parameter int VA_W     = 64,
  parameter int VA_IMPL  = 43,
  parameter int PG_SHIFT = 13,
  parameter int PFN_W    = 32,
  parameter int PA_IMPL  = 44,
  parameter int ASN_W    = 8,
  parameter int CNT_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [VA_W-1:0]             req_va,
  input  logic [1:0]                  req_size,
  input  logic                        req_wr,
  input  logic                        req_phys,
  input  logic                        req_alt,
  input  logic                        req_ptefetch,
  input  logic                        req_nofault,
  input  logic                        pc_priv,
  input  logic [1:0]                  cur_mode,
  input  logic [1:0]                  alt_mode,
  input  logic [ASN_W-1:0]            asn,
  input  logic [VA_W-1:0]             ptbr,
  input  logic [5:0]                  inst_op,
  input  logic [4:0]                  inst_ra,
  output logic [VA_IMPL-PG_SHIFT-1:0] lk_vpn,
  output logic [ASN_W-1:0]            lk_asn,
  input  logic                        lk_hit,
  input  logic [PFN_W-1:0]            lk_pfn,
  input  logic [3:0]                  lk_rd_en,
  input  logic [3:0]                  lk_wr_en,
  input  logic                        lk_for,
  input  logic                        lk_fow,
  output logic                        rsp_valid,
  output logic [VA_W-1:0]             rsp_pa,
  output logic [2:0]                  rsp_fault,
  output logic [VA_W-1:0]             fault_va,
  output logic [16:0]                 mm_stat,
  output logic [VA_W-1:0]             va_form,
  output logic [CNT_W-1:0]            cnt_rd_hit,
  output logic [CNT_W-1:0]            cnt_rd_miss,
  output logic [CNT_W-1:0]            cnt_rd_acv,
  output logic [CNT_W-1:0]            cnt_wr_hit,
  output logic [CNT_W-1:0]            cnt_wr_miss,
  output logic [CNT_W-1:0]            cnt_wr_acv
);
  localparam int SP_HI = 47;
  localparam int SP_LO = 41;
  localparam logic [SP_HI-SP_LO:0] SP_TAG = 7'h7E;
  localparam logic [2:0] F_NONE = 3'd0, F_ALIGN = 3'd1, F_ACV = 3'd2, F_FON = 3'd3,
                         F_MISS = 3'd4, F_PMISS = 3'd5, F_MCHK = 3'd6;
  localparam int B_WR = 0, B_ACV = 1, B_FOR = 2, B_FOW = 3, B_MISS = 4, B_BAD = 5;

  logic [2:0]      amask;
  logic            misalign, canon, superpg;
  logic [1:0]      eff_mode;
  logic [VA_W-1:0] sp_pa, tlb_pa, npa;
  logic [2:0]      nf;
  logic [5:0]      fl;
  logic            ev_hit, ev_miss, ev_acv, rec;

  assign amask    = 3'((4'd1 << req_size) - 4'd1);
  assign misalign = |(req_va[2:0] & amask);
  assign eff_mode = pc_priv ? (req_alt ? alt_mode : 2'd0) : cur_mode;
  assign canon    = (&req_va[VA_W-1:VA_IMPL-1]) | ~(|req_va[VA_W-1:VA_IMPL-1]);
  assign superpg  = req_va[SP_HI:SP_LO] == SP_TAG;
  assign sp_pa    = {{(VA_W-PA_IMPL){1'b0}}, {(PA_IMPL-SP_LO){req_va[SP_LO-1]}}, req_va[SP_LO-1:0]};
  assign tlb_pa   = (VA_W'(lk_pfn) << PG_SHIFT) | VA_W'(req_va[PG_SHIFT-1:0]);
  assign lk_vpn   = req_va[VA_IMPL-1:PG_SHIFT];
  assign lk_asn   = asn;

  always_comb begin
    nf = F_NONE; npa = '0; fl = '0;
    ev_hit = 1'b0; ev_miss = 1'b0; ev_acv = 1'b0;
    if (misalign) begin
      nf = F_ALIGN;
    end else if (req_phys) begin
      npa = req_va;
    end else if (!canon) begin
      nf = F_ACV; ev_acv = 1'b1;
      fl[B_BAD] = 1'b1; fl[B_ACV] = 1'b1; fl[B_WR] = req_wr;
    end else if (superpg) begin
      if (cur_mode != 2'd0) begin
        nf = F_ACV; ev_acv = 1'b1;
        fl[B_ACV] = 1'b1; fl[B_WR] = req_wr;
      end else begin
        npa = sp_pa; ev_hit = 1'b1;
      end
    end else if (!lk_hit) begin
      nf = req_ptefetch ? F_PMISS : F_MISS; ev_miss = 1'b1;
      fl[B_MISS] = 1'b1; fl[B_WR] = req_wr;
    end else begin
      npa = tlb_pa;
      if (req_wr) begin
        fl[B_WR] = 1'b1;
        if (!lk_wr_en[eff_mode]) begin
          nf = F_ACV; ev_acv = 1'b1; fl[B_ACV] = 1'b1; fl[B_FOW] = lk_fow;
        end else if (lk_fow) begin
          nf = F_FON; ev_acv = 1'b1; fl[B_FOW] = 1'b1;
        end else ev_hit = 1'b1;
      end else begin
        if (!lk_rd_en[eff_mode]) begin
          nf = F_ACV; ev_acv = 1'b1; fl[B_ACV] = 1'b1; fl[B_FOR] = lk_for;
        end else if (lk_for) begin
          nf = F_FON; ev_acv = 1'b1; fl[B_FOR] = 1'b1;
        end else ev_hit = 1'b1;
      end
    end
    if (nf == F_NONE && |npa[VA_W-1:PA_IMPL]) nf = F_MCHK;
  end

  assign rec = req_valid && !req_ptefetch && !req_nofault &&
               (nf == F_ACV || nf == F_FON || nf == F_MISS || nf == F_PMISS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_pa <= '0; rsp_fault <= F_NONE;
      fault_va <= '0; mm_stat <= '0; va_form <= '0;
      cnt_rd_hit <= '0; cnt_rd_miss <= '0; cnt_rd_acv <= '0;
      cnt_wr_hit <= '0; cnt_wr_miss <= '0; cnt_wr_acv <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa    <= npa;
        rsp_fault <= nf;
        if (req_wr) begin
          cnt_wr_hit  <= cnt_wr_hit  + CNT_W'(ev_hit);
          cnt_wr_miss <= cnt_wr_miss + CNT_W'(ev_miss);
          cnt_wr_acv  <= cnt_wr_acv  + CNT_W'(ev_acv);
        end else begin
          cnt_rd_hit  <= cnt_rd_hit  + CNT_W'(ev_hit);
          cnt_rd_miss <= cnt_rd_miss + CNT_W'(ev_miss);
          cnt_rd_acv  <= cnt_rd_acv  + CNT_W'(ev_acv);
        end
      end
      if (rec) begin
        fault_va <= req_va;
        mm_stat  <= {inst_op, inst_ra, fl};
        va_form  <= ptbr | (VA_W'(req_va[VA_IMPL-1:PG_SHIFT]) << 3);
      end
    end
  end

  AST_RSP_PAIRS:   assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R1
  AST_RSP_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R1
  AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                     req_valid && req_va[0] && req_size != 2'd0 |=> rsp_fault == F_ALIGN && $stable(mm_stat) && $stable(cnt_rd_acv) && $stable(cnt_wr_acv)); // R2
  AST_PMISS_SRC:   assert property (@(posedge clk) disable iff (!rst_n)
                     rsp_valid && rsp_fault == F_PMISS |-> $past(req_ptefetch)); // R6
  AST_PTE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
                     req_valid && req_ptefetch |=> $stable(mm_stat) && $stable(fault_va) && $stable(va_form)); // R9
  AST_PA_IMPL:     assert property (@(posedge clk) disable iff (!rst_n)
                     rsp_valid && rsp_fault == F_NONE |-> rsp_pa[VA_W-1:PA_IMPL] == '0); // R10
  AST_MISS_CNT:    assert property (@(posedge clk) disable iff (!rst_n)
                     cnt_rd_miss != $past(cnt_rd_miss) || cnt_wr_miss != $past(cnt_wr_miss) |-> rsp_valid && (rsp_fault == F_MISS || rsp_fault == F_PMISS)); // R11
endmodule

// File: tb/sim_dacc_xlate.sv
`timescale 1ns/1ps
module sim_dacc_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_wr = 0, req_phys = 0, req_alt = 0, req_ptefetch = 0, req_nofault = 0, pc_priv = 0;
  logic [63:0] req_va = '0, ptbr = '0;
  logic [1:0]  req_size = '0, cur_mode = '0, alt_mode = '0;
  logic [7:0]  asn = '0;
  logic [5:0]  inst_op = '0;
  logic [4:0]  inst_ra = '0;
  logic        lk_hit = 0, lk_for = 0, lk_fow = 0;
  logic [31:0] lk_pfn = '0;
  logic [3:0]  lk_rd_en = '0, lk_wr_en = '0;
  logic [29:0] lk_vpn;
  logic [7:0]  lk_asn;
  logic        rsp_valid;
  logic [63:0] rsp_pa, fault_va, va_form;
  logic [2:0]  rsp_fault;
  logic [16:0] mm_stat;
  logic [15:0] c_rh, c_rm, c_ra, c_wh, c_wm, c_wa;

  dacc_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_size(req_size),
    .req_wr(req_wr), .req_phys(req_phys), .req_alt(req_alt), .req_ptefetch(req_ptefetch),
    .req_nofault(req_nofault), .pc_priv(pc_priv), .cur_mode(cur_mode), .alt_mode(alt_mode),
    .asn(asn), .ptbr(ptbr), .inst_op(inst_op), .inst_ra(inst_ra), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en), .lk_for(lk_for),
    .lk_fow(lk_fow), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .fault_va(fault_va), .mm_stat(mm_stat), .va_form(va_form),
    .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_rd_acv(c_ra),
    .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm), .cnt_wr_acv(c_wa));

  typedef struct {
    string tag; logic [63:0] pa; logic [2:0] f; logic [63:0] fva;
    logic [16:0] st; logic [63:0] vf; logic [95:0] cnt;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  logic [63:0] m_fva = '0, m_vf = '0;
  logic [16:0] m_st = '0;
  int m_cnt [6] = '{default: 0};

  // staged stimulus
  logic [63:0] s_va, s_ptbr; logic [1:0] s_size, s_cm, s_am; logic s_wr, s_phys, s_alt, s_pte, s_nof, s_pc;
  logic s_hit, s_for, s_fow; logic [31:0] s_pfn; logic [3:0] s_rd, s_wen;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic defaults();
    s_va = 64'h0000_0000_0012_3450; s_size = 2'd3; s_wr = 0; s_phys = 0; s_alt = 0; s_pte = 0; s_nof = 0;
    s_pc = 0; s_cm = 2'd0; s_am = 2'd0; s_ptbr = 64'h0000_0002_0000_0000;
    s_hit = 1; s_pfn = 32'h0000_0ABC; s_rd = 4'hF; s_wen = 4'hF; s_for = 0; s_fow = 0;
  endtask

  task automatic send(input string tag);
    exp_t e;
    logic [2:0] f; logic [63:0] pa; logic [5:0] fl; logic [1:0] md;
    int kind; // 0 none, 1 hit, 2 miss, 3 violation
    @(negedge clk);
    req_valid = 1; req_va = s_va; req_size = s_size; req_wr = s_wr; req_phys = s_phys; req_alt = s_alt;
    req_ptefetch = s_pte; req_nofault = s_nof; pc_priv = s_pc; cur_mode = s_cm; alt_mode = s_am;
    asn = 8'h35; ptbr = s_ptbr; inst_op = 6'h2C; inst_ra = 5'h11;
    lk_hit = s_hit; lk_pfn = s_pfn; lk_rd_en = s_rd; lk_wr_en = s_wen; lk_for = s_for; lk_fow = s_fow;
    #1 chk({tag, " R10 lookup port"}, {90'd0, lk_asn, lk_vpn}, {90'd0, 8'h35, s_va[42:13]});
    f = 0; pa = 0; fl = 0; kind = 0;
    md = !s_pc ? s_cm : (s_alt ? s_am : 2'd0);
    if ((s_size == 1 && s_va[0]) || (s_size == 2 && s_va[1:0] != 0) || (s_size == 3 && s_va[2:0] != 0)) f = 1;
    else if (s_phys) pa = s_va;
    else if (s_va[63:42] != '0 && s_va[63:42] != '1) begin f = 2; fl = 6'h22 | {5'd0, s_wr}; kind = 3; end
    else if (s_va[47:41] == 7'h7E) begin
      if (s_cm != 0) begin f = 2; fl = 6'h02 | {5'd0, s_wr}; kind = 3; end
      else begin pa = {20'd0, {3{s_va[40]}}, s_va[40:0]}; kind = 1; end
    end else if (!s_hit) begin f = s_pte ? 3'd5 : 3'd4; fl = 6'h10 | {5'd0, s_wr}; kind = 2; end
    else begin
      pa = ({32'd0, s_pfn} << 13) | {51'd0, s_va[12:0]};
      if (s_wr) begin
        if (!s_wen[md]) begin f = 2; fl = 6'h03 | (s_fow ? 6'h08 : 6'h00); kind = 3; end
        else if (s_fow) begin f = 3; fl = 6'h09; kind = 3; end
        else kind = 1;
      end else begin
        if (!s_rd[md]) begin f = 2; fl = 6'h02 | (s_for ? 6'h04 : 6'h00); kind = 3; end
        else if (s_for) begin f = 3; fl = 6'h04; kind = 3; end
        else kind = 1;
      end
    end
    if (f == 0 && pa[63:44] != 0) f = 6;
    if (kind != 0) m_cnt[(s_wr ? 3 : 0) + kind - 1]++;
    if (f >= 2 && f <= 5 && !s_pte && !s_nof) begin
      m_fva = s_va; m_st = {6'h2C, 5'h11, fl}; m_vf = s_ptbr | ({34'd0, s_va[42:13]} << 3);
    end
    e.tag = tag; e.pa = pa; e.f = f; e.fva = m_fva; e.st = m_st; e.vf = m_vf;
    e.cnt = {16'(m_cnt[0]), 16'(m_cnt[1]), 16'(m_cnt[2]), 16'(m_cnt[3]), 16'(m_cnt[4]), 16'(m_cnt[5])};
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) chk("R1 unexpected response", 128'd1, 128'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " pa"}, {64'd0, rsp_pa}, {64'd0, e.pa});
        chk({e.tag, " fault code"}, {125'd0, rsp_fault}, {125'd0, e.f});
        chk({e.tag, " R9 fault regs"}, {fault_va, 47'd0, mm_stat}, {e.fva, 47'd0, e.st});
        chk({e.tag, " R9 va_form"}, {64'd0, va_form}, {64'd0, e.vf});
        chk({e.tag, " R11 counters"}, {32'd0, c_rh, c_rm, c_ra, c_wh, c_wm, c_wa}, {32'd0, e.cnt});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", {rsp_valid, rsp_fault, mm_stat, c_rh, c_rm, c_ra, c_wh, c_wm, c_wa}, '0);
    defaults(); send("R10 load hit");
    defaults(); s_wr = 1; s_va = 64'h0000_0000_0777_0008; send("R10 store hit");
    defaults(); s_va = 64'h0000_0000_0012_3451; s_size = 2'd1; send("R2 odd halfword");
    defaults(); s_va = 64'h0000_0800_0000_0004; s_wr = 1; send("R2 quad on long boundary with bad va");
    defaults(); s_va = 64'h0000_0000_0012_3451; s_size = 2'd0; send("R2 byte any address");
    defaults(); s_va = 64'h0000_0800_0000_0000; s_wr = 1; send("R4 non-canonical store");
    defaults(); s_va = 64'h8000_0000_0000_1000; send("R4 non-canonical load");
    defaults(); s_va = 64'hFFFF_FC01_2345_6780; s_hit = 0; send("R5 window bit40 clear");
    defaults(); s_va = 64'hFFFF_FD00_0000_1000; s_hit = 0; send("R5 window bit40 set");
    defaults(); s_va = 64'hFFFF_FC00_0000_2000; s_cm = 2'd3; s_pc = 1; send("R5 window user mode");
    defaults(); s_va = 64'hFFFF_FC00_0000_2000; s_cm = 2'd1; s_wr = 1; send("R5 window store exec");
    defaults(); s_hit = 0; s_va = 64'h0000_0000_4444_6000; send("R6 native miss load");
    defaults(); s_hit = 0; s_wr = 1; s_pte = 1; s_va = 64'h0000_0000_5555_8000; send("R6 pte fetch miss store");
    defaults(); s_wr = 1; s_wen = 4'hE; s_fow = 1; send("R7 store enable fails with fow");
    defaults(); s_wr = 1; s_wen = 4'hE; send("R7 store enable fails");
    defaults(); s_wr = 1; s_fow = 1; send("R7 store fow alone");
    defaults(); s_rd = 4'hE; s_for = 1; send("R8 load enable fails with for");
    defaults(); s_for = 1; send("R8 load for alone");
    defaults(); s_pc = 1; s_cm = 2'd3; s_rd = 4'b0001; send("R3 privileged code kernel");
    defaults(); s_pc = 1; s_alt = 1; s_am = 2'd2; s_rd = 4'b0100; send("R3 alternate mode grants");
    defaults(); s_pc = 1; s_alt = 1; s_am = 2'd2; s_rd = 4'b0001; send("R3 alternate mode denies");
    defaults(); s_cm = 2'd1; s_rd = 4'b0010; s_wen = 4'b1101; s_wr = 1; send("R3 current mode store denied");
    defaults(); s_hit = 0; s_nof = 1; send("R9 no-fault miss keeps regs");
    defaults(); s_pfn = 32'hFFFF_FFFF; send("R10 machine check on hit");
    defaults(); s_phys = 1; s_va = 64'h0000_0000_ABCD_0000; s_hit = 0; send("R12 physical pass");
    defaults(); s_phys = 1; s_va = 64'h0000_0800_0000_0000; s_wr = 1; send("R12 physical skips canonical");
    defaults(); s_phys = 1; s_va = 64'h0004_0000_0000_0000; send("R12 physical machine check");
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    chk("R1 all responses seen", {96'd0, 32'(q.size())}, '0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule